// File: doc/BRIEF.md
# Dual-Read CPU Register File with Stack Pointer

This block holds the architectural registers of a 24-bit processor. Eight 24-bit registers are addressable through a packed operand byte that names two registers at once. Both named registers are read at the same time on two combinational read ports. Either of them can be written on the next rising clock edge.

One of the eight registers is the stack pointer. It can be read and written like any other register. It also has dedicated push and pop controls that move it through a fixed 64 KiB stack window, and the block drives the memory address that the stack access should use in that cycle.

An 8-bit status register and a 24-bit program counter sit beside the file, each with its own load port. Neither of them can be reached through a register address.

Top module: `cpu_regfile`

## Requirements
- R1: In `clusterByte`, bits [5:3] select the register on port A and bits [2:0] select the register on port B. Bits [7:6] have no effect. Register codes are 0=AX, 1=BX, 2=CX, 3=DX, 4=SI, 5=GI, 6=SP, 7=BP.
- R2: `rdDataA` and `rdDataB` show the selected registers combinationally, in the same cycle the byte is applied. The program counter and the status register are never returned on these ports.
- R3: When `wrEnA` is high, `wrDataA` is written to the port A register on the rising edge; `wrEnB` does the same for `wrDataB` and the port B register. If both ports target the same register, port A's data is kept.
- R4: A synchronous active-high `rst` clears every register, the program counter and the status register to zero, except SP, which becomes 0xFEFFFF.
- R5: A push (`push` high, `pop` low) drives `stackAddr` with the current SP in that cycle, and SP becomes SP-1 on the edge.
- R6: A pop (`pop` high, `push` low) drives `stackAddr` with SP+1 in that cycle, and SP becomes SP+1 on the edge.
- R7: A push while SP equals 0xFE0000 raises `stackOverflow` in that cycle and leaves SP unchanged.
- R8: A pop while SP equals 0xFEFFFF raises `stackUnderflow` in that cycle and leaves SP unchanged.
- R9: If either write port targets SP in the same cycle as a push or a pop, SP takes the written value and the push or pop update is dropped.
- R10: `push` and `pop` high together has no effect on SP. In that cycle `stackAddr` equals SP and neither flag rises.
- R11: `pcLoad` loads `pcIn` into the program counter on the edge. `pcInc` adds one to it. When both are high, the load wins. With neither high, the value holds.
- R12: `statusLoad` loads `statusIn` into the 8-bit status register on the edge. Otherwise the status register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| clusterByte | input | 8 | Packed pair of register addresses |
| rdDataA | output | 24 | Value of the port A register |
| rdDataB | output | 24 | Value of the port B register |
| wrEnA | input | 1 | Write enable for the port A register |
| wrDataA | input | 24 | Write data for port A |
| wrEnB | input | 1 | Write enable for the port B register |
| wrDataB | input | 24 | Write data for port B |
| push | input | 1 | Stack push request |
| pop | input | 1 | Stack pop request |
| stackAddr | output | 24 | Memory address for this cycle's stack access |
| stackOverflow | output | 1 | Push refused at the bottom of the stack |
| stackUnderflow | output | 1 | Pop refused at the top of the stack |
| pcLoad | input | 1 | Load the program counter |
| pcInc | input | 1 | Increment the program counter |
| pcIn | input | 24 | New program counter value |
| pcOut | output | 24 | Program counter value |
| statusLoad | input | 1 | Load the status register |
| statusIn | input | 8 | New status value |
| statusOut | output | 8 | Status register value |

## Verification
The reads are combinational, so a corrupted register shows up on `rdDataA` or `rdDataB` in the first cycle a cluster byte names it. A wrong stack pointer shows up earlier still: in the same cycle through `stackAddr` and the two flags, because every push or pop exposes SP directly. A lost or doubled pointer step therefore appears on the next stack access, not only when SP is read back. The program counter and the status register are visible on every cycle, so a stray update is caught one cycle after it happens.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  localparam int DATA_W    = 24;
  localparam int ADDR_W    = 3;
  localparam int NUM_REGS  = 1 << ADDR_W;
  localparam int STATUS_W  = 8;
  localparam int CLUSTER_W = 8;
  localparam int SP_IDX    = 6;
  localparam logic [DATA_W-1:0] STACK_BASE = 24'hFE0000;
  localparam logic [DATA_W-1:0] STACK_TOP  = 24'hFEFFFF;

  typedef struct packed {
    logic [NUM_REGS-1:0] wrSelA;
    logic [NUM_REGS-1:0] wrSelB;
    logic                spDec;
    logic                spInc;
    logic                addrNext;
    logic                pcLoad;
    logic                pcInc;
    logic                statusLoad;
  } ctrlStrobes_t;
endpackage

// File: rtl/regfile_ctrl.sv
module regfile_ctrl
  import regfile_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CLUSTER_W-1:0] clusterByte,
  input  logic                 wrEnA,
  input  logic                 wrEnB,
  input  logic                 push,
  input  logic                 pop,
  input  logic                 pcLoadReq,
  input  logic                 pcIncReq,
  input  logic                 statusLoadReq,
  input  logic [DATA_W-1:0]    spVal,
  output logic [ADDR_W-1:0]    selA,
  output logic [ADDR_W-1:0]    selB,
  output ctrlStrobes_t         strobes,
  output logic                 overflow,
  output logic                 underflow
);
  logic pushOnly, popOnly, spWriteHit;
  logic [NUM_REGS-1:0] decA, decB;

  assign selA = clusterByte[2*ADDR_W-1:ADDR_W];
  assign selB = clusterByte[ADDR_W-1:0];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    assign decA[i] = wrEnA && (selA == ADDR_W'(i));
    assign decB[i] = wrEnB && (selB == ADDR_W'(i));
  end

  assign pushOnly   = push && !pop;
  assign popOnly    = pop && !push;
  assign spWriteHit = decA[SP_IDX] || decB[SP_IDX];
  assign overflow   = pushOnly && (spVal == STACK_BASE);
  assign underflow  = popOnly && (spVal == STACK_TOP);

  always_comb begin
    strobes            = '0;
    strobes.wrSelA     = decA;
    strobes.wrSelB     = decB;
    strobes.spDec      = pushOnly && !overflow && !spWriteHit;
    strobes.spInc      = popOnly && !underflow && !spWriteHit;
    strobes.addrNext   = popOnly;
    strobes.pcLoad     = pcLoadReq;
    strobes.pcInc      = pcIncReq && !pcLoadReq;
    strobes.statusLoad = statusLoadReq;
  end

  // R7: a refused push never steps the pointer
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    overflow |-> !strobes.spDec);
  // R8: a refused pop never steps the pointer
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
    underflow |-> !strobes.spInc);
endmodule

// File: rtl/regfile_dp.sv
module regfile_dp
  import regfile_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrobes_t        strobes,
  input  logic [ADDR_W-1:0]   selA,
  input  logic [ADDR_W-1:0]   selB,
  input  logic [DATA_W-1:0]   wrDataA,
  input  logic [DATA_W-1:0]   wrDataB,
  input  logic [DATA_W-1:0]   pcIn,
  input  logic [STATUS_W-1:0] statusIn,
  output logic [DATA_W-1:0]   rdDataA,
  output logic [DATA_W-1:0]   rdDataB,
  output logic [DATA_W-1:0]   spVal,
  output logic [DATA_W-1:0]   stackAddr,
  output logic [DATA_W-1:0]   pcOut,
  output logic [STATUS_W-1:0] statusOut
);
  logic [NUM_REGS-1:0][DATA_W-1:0] regBank;
  logic [DATA_W-1:0]   pcReg;
  logic [STATUS_W-1:0] statusReg;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [DATA_W-1:0] RST_VAL = (i == SP_IDX) ? STACK_TOP : '0;
    logic [DATA_W-1:0] q;
    if (i == SP_IDX) begin : g_sp
      always_ff @(posedge clk) begin
        if (rst)                    q <= RST_VAL;
        else if (strobes.wrSelA[i]) q <= wrDataA;
        else if (strobes.wrSelB[i]) q <= wrDataB;
        else if (strobes.spDec)     q <= q - DATA_W'(1);
        else if (strobes.spInc)     q <= q + DATA_W'(1);
      end
    end else begin : g_gp
      always_ff @(posedge clk) begin
        if (rst)                    q <= RST_VAL;
        else if (strobes.wrSelA[i]) q <= wrDataA;
        else if (strobes.wrSelB[i]) q <= wrDataB;
      end
    end
    assign regBank[i] = q;
  end

  always_ff @(posedge clk) begin
    if (rst)                 pcReg <= '0;
    else if (strobes.pcLoad) pcReg <= pcIn;
    else if (strobes.pcInc)  pcReg <= pcReg + DATA_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)                     statusReg <= '0;
    else if (strobes.statusLoad) statusReg <= statusIn;
  end

  assign rdDataA   = regBank[selA];
  assign rdDataB   = regBank[selB];
  assign spVal     = regBank[SP_IDX];
  assign stackAddr = strobes.addrNext ? spVal + DATA_W'(1) : spVal;
  assign pcOut     = pcReg;
  assign statusOut = statusReg;

  // R4: reset leaves the pointer at the top of the stack window
  assert_reset_sp_R4: assert property (@(posedge clk)
    rst |=> (spVal == STACK_TOP));
  // R5: an accepted push lowers SP by exactly one
  assert_push_step_R5: assert property (@(posedge clk) disable iff (rst)
    strobes.spDec |=> (spVal == $past(spVal) - DATA_W'(1)));
  // R6: an accepted pop raises SP by exactly one
  assert_pop_step_R6: assert property (@(posedge clk) disable iff (rst)
    strobes.spInc |=> (spVal == $past(spVal) + DATA_W'(1)));
  // R11: a load puts the input on the program counter
  assert_pc_load_R11: assert property (@(posedge clk) disable iff (rst)
    strobes.pcLoad |=> (pcOut == $past(pcIn)));
  // R12: status holds without a load
  assert_status_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !strobes.statusLoad |=> $stable(statusOut));
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile
  import regfile_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CLUSTER_W-1:0] clusterByte,
  output logic [DATA_W-1:0]    rdDataA,
  output logic [DATA_W-1:0]    rdDataB,
  input  logic                 wrEnA,
  input  logic [DATA_W-1:0]    wrDataA,
  input  logic                 wrEnB,
  input  logic [DATA_W-1:0]    wrDataB,
  input  logic                 push,
  input  logic                 pop,
  output logic [DATA_W-1:0]    stackAddr,
  output logic                 stackOverflow,
  output logic                 stackUnderflow,
  input  logic                 pcLoad,
  input  logic                 pcInc,
  input  logic [DATA_W-1:0]    pcIn,
  output logic [DATA_W-1:0]    pcOut,
  input  logic                 statusLoad,
  input  logic [STATUS_W-1:0]  statusIn,
  output logic [STATUS_W-1:0]  statusOut
);
  ctrlStrobes_t      strobes;
  logic [ADDR_W-1:0] selA, selB;
  logic [DATA_W-1:0] spVal;

  regfile_ctrl u_ctrl (
    .clk(clk), .rst(rst), .clusterByte(clusterByte),
    .wrEnA(wrEnA), .wrEnB(wrEnB), .push(push), .pop(pop),
    .pcLoadReq(pcLoad), .pcIncReq(pcInc), .statusLoadReq(statusLoad),
    .spVal(spVal), .selA(selA), .selB(selB), .strobes(strobes),
    .overflow(stackOverflow), .underflow(stackUnderflow)
  );

  regfile_dp u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .selA(selA), .selB(selB),
    .wrDataA(wrDataA), .wrDataB(wrDataB), .pcIn(pcIn), .statusIn(statusIn),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .spVal(spVal),
    .stackAddr(stackAddr), .pcOut(pcOut), .statusOut(statusOut)
  );
endmodule

// File: tb/tb_cpu_regfile.sv
module tb_cpu_regfile;
  logic clk = 0;
  logic rst = 1;
  logic [7:0]  clusterByte = 0;
  logic [23:0] rdDataA, rdDataB, wrDataA = 0, wrDataB = 0, stackAddr, pcIn = 0, pcOut;
  logic wrEnA = 0, wrEnB = 0, push = 0, pop = 0, pcLoad = 0, pcInc = 0, statusLoad = 0;
  logic stackOverflow, stackUnderflow;
  logic [7:0] statusIn = 0, statusOut;

  always #2.5 clk = ~clk;

  cpu_regfile dut (.*);

  typedef struct {
    string req;
    logic [23:0] a, b, addr, pc;
    logic ovf, unf;
    logic [7:0] st;
  } expItem_t;

  expItem_t q[$];
  logic [23:0] mReg[8];
  logic [23:0] mPc;
  logic [7:0]  mSt;
  int tests = 0, fails = 0;
  bit done = 0;

  function automatic logic [7:0] cl(input int a, input int b);
    return {2'b00, 3'(a), 3'(b)};
  endfunction

  task automatic step(input string req, input logic [7:0] c,
                      input bit wa, input logic [23:0] da,
                      input bit wb, input logic [23:0] db,
                      input bit pu, input bit po,
                      input bit pl, input bit pi, input logic [23:0] pv,
                      input bit sl, input logic [7:0] sv);
    expItem_t e;
    logic [23:0] sp;
    int ia, ib;
    @(posedge clk); #1;
    clusterByte = c; wrEnA = wa; wrDataA = da; wrEnB = wb; wrDataB = db;
    push = pu; pop = po; pcLoad = pl; pcInc = pi; pcIn = pv;
    statusLoad = sl; statusIn = sv;
    ia = int'(c[5:3]); ib = int'(c[2:0]);
    sp = mReg[6];
    e.req = req; e.a = mReg[ia]; e.b = mReg[ib]; e.pc = mPc; e.st = mSt;
    e.ovf = pu && !po && sp == 24'hFE0000;
    e.unf = po && !pu && sp == 24'hFEFFFF;
    e.addr = (po && !pu) ? sp + 24'd1 : sp;
    q.push_back(e);
    if (!((wa && ia == 6) || (wb && ib == 6))) begin
      if (pu && !po && !e.ovf) mReg[6] = sp - 24'd1;
      if (po && !pu && !e.unf) mReg[6] = sp + 24'd1;
    end
    if (wb) mReg[ib] = db;
    if (wa) mReg[ia] = da;
    if (pl) mPc = pv; else if (pi) mPc = mPc + 24'd1;
    if (sl) mSt = sv;
  endtask

  task automatic rd(input string req, input int a, input int b);
    step(req, cl(a, b), 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic chk(input string req, input string what, input logic [23:0] act, input logic [23:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: compare the oldest expected item in the middle of each cycle
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        expItem_t e;
        e = q.pop_front();
        chk(e.req, "rdDataA", rdDataA, e.a);
        chk(e.req, "rdDataB", rdDataB, e.b);
        chk(e.req, "stackAddr", stackAddr, e.addr);
        chk(e.req, "stackOverflow", {23'd0, stackOverflow}, {23'd0, e.ovf});
        chk(e.req, "stackUnderflow", {23'd0, stackUnderflow}, {23'd0, e.unf});
        chk(e.req, "pcOut", pcOut, e.pc);
        chk(e.req, "statusOut", {16'd0, statusOut}, {16'd0, e.st});
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) mReg[i] = (i == 6) ? 24'hFEFFFF : 24'h0;
    mPc = 0; mSt = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R4: reset state of every register
    for (int i = 0; i < 8; i += 2) rd("R4", i, i + 1);
    // R3: both ports write in one cycle
    step("R3", cl(0, 1), 1, 24'h111111, 1, 24'h222222, 0, 0, 0, 0, 0, 0, 0);
    // R1: upper bits ignored on read
    step("R1", 8'hC1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R1", 8'h81, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R1/R2: fill every register with a distinct value and read in pairs
    for (int i = 0; i < 8; i++)
      step("R1", {2'b11, 3'(i), 3'(7 - i)}, 1, 24'hA00000 + 24'(i * 24'h010101), 0, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) rd("R2", i, (i + 3) % 8);
    // R3: same register on both ports, port A wins
    step("R3", cl(2, 2), 1, 24'h0AAAAA, 1, 24'h0BBBBB, 0, 0, 0, 0, 0, 0, 0);
    rd("R3", 2, 2);
    // restore SP to the top through port B
    step("R9", cl(0, 6), 0, 0, 1, 24'hFEFFFF, 0, 0, 0, 0, 0, 0, 0);
    // R5: pushes
    step("R5", cl(6, 0), 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    step("R5", cl(6, 0), 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    rd("R5", 6, 6);
    // R6: pops back to the top
    step("R6", cl(6, 1), 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R6", cl(6, 1), 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    // R8: pop at the top refused
    step("R8", cl(6, 1), 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    rd("R8", 6, 0);
    // R7: push at the bottom refused
    step("R7", cl(6, 0), 1, 24'hFE0000, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R7", cl(6, 0), 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    rd("R7", 6, 6);
    step("R6", cl(6, 0), 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    rd("R6", 6, 0);
    // R9: explicit write beats push and pop
    step("R9", cl(6, 0), 1, 24'hFE8000, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    rd("R9", 6, 6);
    step("R9", cl(0, 6), 0, 0, 1, 24'hFE4000, 0, 1, 0, 0, 0, 0, 0);
    rd("R9", 6, 6);
    // R10: push and pop together
    step("R10", cl(6, 6), 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0);
    rd("R10", 6, 6);
    // R11: program counter
    step("R11", cl(0, 1), 0, 0, 0, 0, 0, 0, 1, 0, 24'h123456, 0, 0);
    step("R11", cl(0, 1), 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    step("R11", cl(0, 1), 0, 0, 0, 0, 0, 0, 1, 1, 24'h00FFFF, 0, 0);
    step("R11", cl(0, 1), 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    rd("R11", 0, 1);
    // R12: status register
    step("R12", cl(3, 4), 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h5A);
    rd("R12", 3, 4);
    step("R12", cl(3, 4), 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'hC3);
    rd("R12", 5, 7);
    rd("R12", 5, 7);
    // R4: reset again mid-run
    @(posedge clk); #1 rst = 1;
    @(posedge clk); #1 rst = 0;
    for (int i = 0; i < 8; i++) mReg[i] = (i == 6) ? 24'hFEFFFF : 24'h0;
    mPc = 0; mSt = 0;
    rd("R4", 6, 2);
    rd("R4", 5, 7);
    repeat (2) @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule